// File: doc/BRIEF.md
# Cache Maintenance Line Walker

This block turns one maintenance command into a series of single-line operations on a set-associative tag array. A command carries a start address, a byte count, a scope selector, a way mask and an operation code. In range scope the walker widens the byte span to whole lines and then asks the tag array to look up each line address in turn. In whole-cache scope it sweeps every set over the ways marked present. In way scope it sweeps every set over the requested ways that are also present, which is how locked ways are reached without disturbing the rest.

The tag array is reached through a request/acknowledge port. The walker keeps one request open until it is acknowledged, and only then moves to the next line. When the final operation has been acknowledged it pulses `done`. Commands are refused while a walk is in progress. A command whose rounded span exceeds the per-command byte limit, or that uses the reserved scope code, is rejected straight away and must be split or corrected by the requester.

Top module: `cache_line_walker`

## Requirements
- R1: In range scope (cmd_scope = 0) the first request carries the start address rounded down to a line boundary, with `tag_by_addr` high.
- R2: In range scope one request is issued per line, in ascending address order, up to and including the line that holds byte start+size-1; `tag_set` is the line address divided by the line size, modulo the set count.
- R3: A range command with size 0 issues no request and pulses `done` in the cycle after acceptance.
- R4: A range command whose line-rounded span exceeds MAX_BYTES pulses `cmd_reject` in the cycle after acceptance and issues no request and no `done`.
- R5: In whole-cache scope (cmd_scope = 1) requests visit every set in ascending order and, within a set, every way set in `present_ways` in ascending order, with `tag_by_addr` low; `cmd_ways` has no effect.
- R6: In way scope (cmd_scope = 2) only ways set in both `cmd_ways` and `present_ways` are visited, in the same set-outer, way-inner order; if none remain, `done` pulses in the cycle after acceptance with no request.
- R7: An open request and its address, set, way and code hold steady until `tag_ack` is sampled high; the walker never advances without an acknowledge.
- R8: `done` is a one-cycle pulse raised in the cycle after the last operation is acknowledged.
- R9: While a walk is in progress `cmd_ready` is low and a presented command is ignored.
- R10: During and straight after reset there is no request, no `done`, no reject and `cmd_ready` is high; a reset during a walk abandons it.
- R11: Every request of a command carries that command's code on `tag_code`.
- R12: The reserved scope code (cmd_scope = 3) is rejected as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command presented |
| cmd_ready | output | 1 | Walker idle and able to take a command |
| cmd_start | input | ADDR_W | Start byte address (range scope) |
| cmd_size | input | ADDR_W | Byte count (range scope) |
| cmd_scope | input | 2 | 0 range, 1 whole cache, 2 selected ways, 3 reserved |
| cmd_ways | input | WAYS | Way selection for way scope |
| cmd_code | input | CODE_W | Operation code forwarded to the tag array |
| present_ways | input | WAYS | Ways that exist in the array |
| tag_req | output | 1 | Line operation request |
| tag_by_addr | output | 1 | Request is an address lookup (range scope) |
| tag_addr | output | ADDR_W | Line-aligned address of the request |
| tag_set | output | log2(SETS) | Set index of the request |
| tag_way | output | log2(WAYS) | Way index of a sweep request |
| tag_code | output | CODE_W | Operation code of the request |
| tag_ack | input | 1 | Tag array has taken the request |
| done | output | 1 | One-cycle completion pulse |
| cmd_reject | output | 1 | One-cycle pulse: command refused as over-limit or reserved |

## Verification
Range commands are tried with aligned spans, starts inside a line, a one-byte span sitting at the end of a line, a zero size, a span exactly at the limit, and spans one byte and one misaligned byte beyond it; these separate the round-down of the start from the round-up of the end and place the limit comparison precisely. A range that crosses the top set index shows the set index wrapping. Sweeps are run with a present mask that has a hole, with a way mask that partly overlaps the present ways and with one that misses them entirely, which tells apart skipping absent ways, honouring the requested ways and the empty case. Stalled acknowledges and a command pushed in mid-walk show that progress follows only acknowledges and that a busy walker ignores new work.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    LW_SCOPE_RANGE = 2'd0,
    LW_SCOPE_ALL   = 2'd1,
    LW_SCOPE_WAYS  = 2'd2,
    LW_SCOPE_RSVD  = 2'd3
  } lw_scope_e;
endpackage

// File: rtl/lw_range_calc.sv
// Widens a byte span to whole lines and checks it against the command limit.
module lw_range_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int MAX_BYTES  = 4194304 - 128
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] size,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W+1:0] lines,
  output logic              over
);
  localparam int W      = ADDR_W + 2;
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam logic [W-1:0] LINE_MASK = W'(LINE_BYTES - 1);
  localparam logic [W-1:0] MAX_LINES = W'(MAX_BYTES / LINE_BYTES);

  function automatic logic [ADDR_W-1:0] f_align_down(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(LINE_BYTES - 1);
  endfunction

  function automatic logic [W-1:0] f_line_count(input logic [ADDR_W-1:0] s,
                                                input logic [ADDR_W-1:0] n);
    logic [W-1:0] lo, hi;
    lo = W'(s) & ~LINE_MASK;
    hi = W'(s) + W'(n);
    if (n == '0) return '0;
    return (hi - lo + LINE_MASK) >> LINE_SH;
  endfunction

  assign base  = f_align_down(start);
  assign lines = f_line_count(start, size);
  assign over  = lines > MAX_LINES;
endmodule

// File: rtl/lw_way_pick.sv
// Lowest way at or above a starting index that is set in a mask.
module lw_way_pick #(
  parameter int WAYS  = 32,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] mask,
  input  logic [WAY_W:0]  from,
  output logic            found,
  output logic [WAY_W-1:0] idx
);
  localparam int FW = WAY_W + 1;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (mask[i] && (FW'(i) >= from)) begin
        found = 1'b1;
        idx   = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/cache_line_walker.sv
module cache_line_walker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SETS       = 512,
  parameter int WAYS       = 32,
  parameter int CODE_W     = 3,
  parameter int MAX_BYTES  = 4194304 - 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [ADDR_W-1:0]         cmd_start,
  input  logic [ADDR_W-1:0]         cmd_size,
  input  logic [1:0]                cmd_scope,
  input  logic [WAYS-1:0]           cmd_ways,
  input  logic [CODE_W-1:0]         cmd_code,
  input  logic [WAYS-1:0]           present_ways,
  output logic                      tag_req,
  output logic                      tag_by_addr,
  output logic [ADDR_W-1:0]         tag_addr,
  output logic [$clog2(SETS)-1:0]   tag_set,
  output logic [$clog2(WAYS)-1:0]   tag_way,
  output logic [CODE_W-1:0]         tag_code,
  input  logic                      tag_ack,
  output logic                      done,
  output logic                      cmd_reject
);
  import lw_pkg::*;

  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int CNT_W   = ADDR_W + 2;

  // walker state
  logic              busy;
  logic              sweep;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  lines_left;
  logic [SET_W-1:0]  cur_set;
  logic [WAY_W-1:0]  cur_way;
  logic [WAYS-1:0]   sweep_mask;
  logic [CODE_W-1:0] code_q;
  logic              done_q;
  logic              reject_q;

  // named events
  lw_scope_e         scope;
  logic              accept;
  logic              line_ack;
  logic              last_op;
  logic              cmd_bad;
  logic              cmd_empty;

  logic [ADDR_W-1:0] rng_base;
  logic [CNT_W-1:0]  rng_lines;
  logic              rng_over;
  logic [WAYS-1:0]   new_mask;
  logic [WAYS-1:0]   first_src;
  logic              first_found;
  logic [WAY_W-1:0]  first_idx;
  logic              nxt_found;
  logic [WAY_W-1:0]  nxt_idx;

  assign scope = lw_scope_e'(cmd_scope);

  lw_range_calc #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
  ) u_range (
    .start(cmd_start), .size(cmd_size),
    .base(rng_base), .lines(rng_lines), .over(rng_over)
  );

  assign new_mask  = (scope == LW_SCOPE_WAYS) ? (cmd_ways & present_ways) : present_ways;
  assign first_src = busy ? sweep_mask : new_mask;

  lw_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick_first (
    .mask(first_src), .from('0), .found(first_found), .idx(first_idx)
  );

  lw_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick_next (
    .mask(sweep_mask), .from({1'b0, cur_way} + (WAY_W+1)'(1)),
    .found(nxt_found), .idx(nxt_idx)
  );

  assign accept    = cmd_valid && !busy;
  assign line_ack  = busy && tag_ack;
  assign last_op   = sweep ? (!nxt_found && (cur_set == SET_W'(SETS - 1)))
                           : (lines_left == CNT_W'(1));
  assign cmd_bad   = (scope == LW_SCOPE_RSVD) || ((scope == LW_SCOPE_RANGE) && rng_over);
  assign cmd_empty = (scope == LW_SCOPE_RANGE) ? (rng_lines == '0) : !first_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      sweep      <= 1'b0;
      cur_addr   <= '0;
      lines_left <= '0;
      cur_set    <= '0;
      cur_way    <= '0;
      sweep_mask <= '0;
      code_q     <= '0;
      done_q     <= 1'b0;
      reject_q   <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      if (accept) begin
        if (cmd_bad) begin
          reject_q <= 1'b1;
        end else if (cmd_empty) begin
          done_q <= 1'b1;
        end else begin
          busy       <= 1'b1;
          sweep      <= (scope != LW_SCOPE_RANGE);
          code_q     <= cmd_code;
          cur_addr   <= (scope == LW_SCOPE_RANGE) ? rng_base : '0;
          lines_left <= rng_lines;
          cur_set    <= '0;
          cur_way    <= (scope == LW_SCOPE_RANGE) ? '0 : first_idx;
          sweep_mask <= new_mask;
        end
      end else if (line_ack) begin
        if (last_op) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else if (sweep) begin
          if (nxt_found) begin
            cur_way <= nxt_idx;
          end else begin
            cur_set <= cur_set + SET_W'(1);
            cur_way <= first_idx;
          end
        end else begin
          lines_left <= lines_left - CNT_W'(1);
          cur_addr   <= cur_addr + ADDR_W'(LINE_BYTES);
        end
      end
    end
  end

  assign cmd_ready   = !busy;
  assign tag_req     = busy;
  assign tag_by_addr = busy && !sweep;
  assign tag_addr    = cur_addr;
  assign tag_set     = sweep ? cur_set : cur_addr[LINE_SH +: SET_W];
  assign tag_way     = cur_way;
  assign tag_code    = code_q;
  assign done        = done_q;
  assign cmd_reject  = reject_q;
endmodule

// File: rtl/lw_walker_chk.sv
module lw_walker_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SET_W      = 9,
  parameter int WAY_W      = 5,
  parameter int WAYS       = 32,
  parameter int CODE_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_reject,
  input logic              done,
  input logic              tag_req,
  input logic              tag_by_addr,
  input logic              tag_ack,
  input logic [ADDR_W-1:0] tag_addr,
  input logic [SET_W-1:0]  tag_set,
  input logic [WAY_W-1:0]  tag_way,
  input logic [CODE_W-1:0] tag_code,
  input logic [WAYS-1:0]   present_ways,
  input logic              accept,
  input logic              line_ack
);
  localparam int LINE_SH = $clog2(LINE_BYTES);

  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req && tag_by_addr) |-> (tag_addr[LINE_SH-1:0] == '0));

  p_range_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req && tag_by_addr && tag_ack) |=>
      (!tag_req || (tag_addr == $past(tag_addr) + ADDR_W'(LINE_BYTES))));

  p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> (!tag_req && !done));

  p_way_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req && !tag_by_addr) |-> present_ways[tag_way]);

  p_sweep_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req && !tag_by_addr && tag_ack) |=>
      (!tag_req || (tag_set > $past(tag_set)) ||
       ((tag_set == $past(tag_set)) && (tag_way > $past(tag_way)))));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req && !tag_ack) |=>
      (tag_req && $stable(tag_addr) && $stable(tag_set) &&
       $stable(tag_way) && $stable(tag_code)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(line_ack) || $past(accept)));

  p_busy_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req |-> !cmd_ready);
endmodule

bind cache_line_walker lw_walker_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SET_W(SET_W),
  .WAY_W(WAY_W), .WAYS(WAYS), .CODE_W(CODE_W)
) u_lw_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_reject(cmd_reject),
  .done(done), .tag_req(tag_req), .tag_by_addr(tag_by_addr), .tag_ack(tag_ack),
  .tag_addr(tag_addr), .tag_set(tag_set), .tag_way(tag_way), .tag_code(tag_code),
  .present_ways(present_ways), .accept(accept), .line_ack(line_ack)
);

// File: tb/cache_line_walker_bench.sv
module cache_line_walker_bench;
  localparam int AW = 16, LB = 16, NS = 8, NW = 4, CW = 3, MAXB = 240;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          cmd_valid, cmd_ready;
  logic [AW-1:0] cmd_start, cmd_size;
  logic [1:0]    cmd_scope;
  logic [NW-1:0] cmd_ways, present_ways;
  logic [CW-1:0] cmd_code;
  logic          tag_req, tag_by_addr, tag_ack, done, cmd_reject;
  logic [AW-1:0] tag_addr;
  logic [2:0]    tag_set;
  logic [1:0]    tag_way;
  logic [CW-1:0] tag_code;

  cache_line_walker #(
    .ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW), .CODE_W(CW), .MAX_BYTES(MAXB)
  ) u_cache_line_walker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start(cmd_start), .cmd_size(cmd_size), .cmd_scope(cmd_scope),
    .cmd_ways(cmd_ways), .cmd_code(cmd_code), .present_ways(present_ways),
    .tag_req(tag_req), .tag_by_addr(tag_by_addr), .tag_addr(tag_addr),
    .tag_set(tag_set), .tag_way(tag_way), .tag_code(tag_code),
    .tag_ack(tag_ack), .done(done), .cmd_reject(cmd_reject)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int exp_n;
  bit exp_rej, exp_range;
  int exp_addr[64], exp_set[64], exp_way[64];

  // stimulus table: start, size, expected first line, expected lines (-1 = reject)
  localparam int NV = 8;
  localparam int V_START[NV] = '{'h100, 'h105, 'h10F, 'h200, 'h300, 'h301, 'h300, 'h071};
  localparam int V_SIZE [NV] = '{'h040, 'h010, 1,     0,     'h0F0, 'h0F0, 'h0F1, 'h020};
  localparam int V_FIRST[NV] = '{'h100, 'h100, 'h100, 'h200, 'h300, 0,     0,     'h070};
  localparam int V_LINES[NV] = '{4,     2,     1,     0,     15,    -1,    -1,    3};

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  task automatic plan_range(input int first, input int n);
    exp_range = 1; exp_rej = (n < 0); exp_n = (n < 0) ? 0 : n;
    for (int k = 0; k < exp_n; k++) begin
      exp_addr[k] = (first + k * LB) & 'hFFFF;
      exp_set[k]  = (exp_addr[k] / LB) % NS;
      exp_way[k]  = 0;
    end
  endtask

  task automatic plan_sweep(input logic [NW-1:0] m);
    exp_range = 0; exp_rej = 0; exp_n = 0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        if (m[w]) begin
          exp_set[exp_n] = s; exp_way[exp_n] = w; exp_addr[exp_n] = 0; exp_n++;
        end
  endtask

  task automatic run_cmd(input int st, input int sz, input logic [1:0] sc,
                         input logic [NW-1:0] wm, input logic [CW-1:0] cd,
                         input bit stall, input bit inject, input string rq);
    int i = 0;
    int guard = 0;
    bit fin = 0;
    bit held = 0;
    bit injected = 0;
    @(negedge clk);
    cmd_start = AW'(st); cmd_size = AW'(sz); cmd_scope = sc;
    cmd_ways = wm; cmd_code = cd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!fin) begin
      if (cmd_reject) begin
        chk(exp_rej, rq, "unexpected reject", 1, 0);
        chk(!tag_req, rq, "request alongside reject", int'(tag_req), 0);
        chk(i == 0, rq, "operations before reject", i, 0);
        fin = 1;
      end else if (done) begin
        chk(!exp_rej, rq, "done where reject expected", 1, 0);
        chk(i == exp_n, rq, "operations before done", i, exp_n);
        fin = 1;
      end else if (tag_req) begin
        chk(!cmd_ready, "R9", "ready while busy", int'(cmd_ready), 0);
        if (i >= exp_n) begin
          chk(0, rq, "extra request", i, exp_n);
          fin = 1;
        end else begin
          if (exp_range) begin
            chk(tag_by_addr, "R2", "lookup flag", int'(tag_by_addr), 1);
            chk(int'(tag_addr) == exp_addr[i], (i == 0) ? "R1" : "R2", "line address",
                int'(tag_addr), exp_addr[i]);
          end else begin
            chk(!tag_by_addr, rq, "sweep flag", int'(tag_by_addr), 0);
            chk(int'(tag_way) == exp_way[i], rq, "way index", int'(tag_way), exp_way[i]);
          end
          chk(int'(tag_set) == exp_set[i], exp_range ? "R2" : rq, "set index",
              int'(tag_set), exp_set[i]);
          chk(tag_code == cd, "R11", "code", int'(tag_code), int'(cd));
          if (stall && !held) held = 1;
          else begin tag_ack = 1'b1; held = 0; i++; end
          if (inject && !injected && i == 1 && exp_n > 1) begin
            injected = 1;
            cmd_valid = 1'b1; cmd_scope = 2'd1; cmd_start = 16'h0400; cmd_size = 16'h0010;
          end
        end
      end else begin
        chk(0, "R8", "idle without done", 0, 1);
        fin = 1;
      end
      if (!fin) begin
        @(negedge clk);
        tag_ack = 1'b0; cmd_valid = 1'b0; guard++;
        if (guard > 500) begin chk(0, "R8", "no completion", guard, 0); fin = 1; end
      end
    end
    tag_ack = 1'b0;
    @(negedge clk);
    chk(!done, "R8", "done beyond one cycle", int'(done), 0);
    chk(!cmd_reject, "R4", "reject beyond one cycle", int'(cmd_reject), 0);
    chk(!tag_req, "R8", "request after finish", int'(tag_req), 0);
    chk(cmd_ready, "R9", "ready after finish", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_start = '0; cmd_size = '0; cmd_scope = '0;
    cmd_ways = '0; cmd_code = '0; tag_ack = 1'b0; present_ways = 4'b1011;
    repeat (3) @(negedge clk);
    chk(!tag_req && !done && !cmd_reject, "R10", "outputs in reset", int'(tag_req), 0);
    chk(cmd_ready, "R10", "ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tag_req && !done && !cmd_reject && cmd_ready, "R10", "idle after reset",
        int'(tag_req), 0);

    // table of range commands
    for (int v = 0; v < NV; v++) begin
      plan_range(V_FIRST[v], V_LINES[v]);
      run_cmd(V_START[v], V_SIZE[v], 2'd0, 4'hF, CW'(v),
              0, 0, (V_LINES[v] < 0) ? "R4" : ((V_LINES[v] == 0) ? "R3" : "R2"));
    end

    // whole cache, present mask with a hole; cmd_ways left at zero has no effect
    plan_sweep(4'b1011);
    run_cmd(0, 0, 2'd1, 4'b0000, 3'd5, 0, 0, "R5");

    // way scope, partial overlap with present ways
    plan_sweep(4'b0110 & 4'b1011);
    run_cmd(0, 0, 2'd2, 4'b0110, 3'd6, 0, 0, "R6");

    // way scope, no present way selected
    plan_sweep(4'b0100 & 4'b1011);
    run_cmd(0, 0, 2'd2, 4'b0100, 3'd1, 0, 0, "R6");

    // reserved scope
    exp_range = 1; exp_rej = 1; exp_n = 0;
    run_cmd('h100, 'h10, 2'd3, 4'hF, 3'd2, 0, 0, "R12");

    // stalled acknowledges across a set wrap
    plan_range('h070, 3);
    run_cmd('h071, 'h20, 2'd0, 4'hF, 3'd3, 1, 0, "R7");

    // command pushed while busy is ignored
    plan_range('h100, 4);
    run_cmd('h100, 'h40, 2'd0, 4'hF, 3'd4, 0, 1, "R9");

    // reset in the middle of a walk
    @(negedge clk);
    cmd_start = 16'h0100; cmd_size = 16'h0040; cmd_scope = 2'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(tag_req, "R10", "walk started before reset", int'(tag_req), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!tag_req && cmd_ready, "R10", "walk abandoned by reset", int'(tag_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tag_req && !done, "R10", "idle after mid-walk reset", int'(done), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule